// File: doc/BRIEF.md
# Processor Tick Timer with Match Modes

This block is a tick timer for a small processor core. It keeps a 32-bit count register and a control register that holds a match period, an interrupt enable, a sticky interrupt-pending flag and a two-bit mode. The count steps by one on each cycle where the tick-enable input is high, as long as the mode is not the disabled one. A nominal tick is 50 ns, which is a 20 MHz tick rate.

A match is detected when the low period bits of the count equal the period field. The count bits above the period field take no part in the comparison. The comparison is an equality test, so a period that is not ahead of the masked count is reached only after the masked count wraps through its maximum. On a match, the pending flag is set if interrupts are enabled, and then the mode decides what happens next:
- restart clears the count to zero;
- one-shot freezes the count until software writes the control register;
- continuous keeps counting.

Software reaches both registers through a single-cycle register port. A write takes effect at the next clock edge, and a read returns its value combinationally.

A three-state machine sequences the counter:
- ST_IDLE: not counting.
- ST_RUN: counting.
- ST_HALT: frozen after a one-shot match.

Its transitions are:
- IDLE→RUN or HALT→RUN: a control write with a nonzero mode.
- RUN→IDLE or HALT→IDLE: a control write with mode 00.
- RUN→HALT: a match in one-shot mode.
- Any other cycle: the state holds.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control register (address 0) and the count register (address 1) both read 0, and `irq` is low.
- R2: In a nonzero mode, the count increases by exactly 1 per tick. With mode 00 the count does not move. A tick that arrives in a cycle with any register write is dropped.
- R3: A match occurs when count bits 27:0 equal the period field, and count bits 31:28 are ignored. A period at or behind the masked count matches only after the masked count wraps through 0x0FFFFFFF.
- R4: On a match with interrupt enable (control bit 29) set, the pending bit (bit 28) becomes 1. With enable clear, a match leaves the pending bit at 0. `irq` equals pending AND enable.
- R5: The pending bit is sticky. A control write with bit 28 = 0 clears it, and a write with bit 28 = 1 leaves it unchanged.
- R6: In restart mode (bits 31:30 = 01), the tick that produces a match leaves the count at 0.
- R7: In one-shot mode (10), the count stops at the matching value and ignores further ticks. A control write with a nonzero mode resumes counting.
- R8: In continuous mode (11), the count keeps advancing past a match.
- R9: A count write (address 1) in the same cycle as a tick loads the written value, and the increment is lost.
- R10: The control register reads back as mode in bits 31:30 (00 disabled, 01 restart, 10 one-shot, 11 continuous), enable in bit 29, pending in bit 28 and period in bits 27:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One timer tick when high at a clock edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the count register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
All results are due one clock edge after the stimulus that causes them:
- A write or a tick applied before edge k shows up in `reg_rdata` and `irq` just after edge k.
- A match sets the pending bit on the same edge as the count update that produces it.

The bench changes inputs on falling edges and holds each tick or write for exactly one rising edge. It reads the registers 1 ns after the next falling edge, so every sample falls after the edge that produces the result and before the next one. Match cases are sampled on the tick just before the match, and again on the match tick itself, so an early or late match is visible.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        TM_OFF     = 2'b00,
        TM_RESTART = 2'b01,
        TM_ONESHOT = 2'b10,
        TM_FREE    = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_HALT = 2'b10
    } tstate_e;

    localparam int unsigned HDR_BITS = 4;
endpackage

// File: rtl/tt_ctl_reg.sv
module tt_ctl_reg
    import tt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PER_W = DATA_W - HDR_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic             hit,
    output tmode_e           mode_o,
    output logic             ie_o,
    output logic             pend_o,
    output logic [PER_W-1:0] period_o
);
    localparam int unsigned IE_BIT   = PER_W + 1;
    localparam int unsigned PEND_BIT = PER_W;

    tmode_e           mode_q;
    logic             ie_q;
    logic             pend_q;
    logic [PER_W-1:0] period_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= TM_OFF;
            ie_q     <= 1'b0;
            period_q <= '0;
        end else if (ctl_wr) begin
            mode_q   <= tmode_e'(wdata[DATA_W-1:DATA_W-2]);
            ie_q     <= wdata[IE_BIT];
            period_q <= wdata[PER_W-1:0];
        end
    end

    // Sticky pending: software may only clear it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (ctl_wr) begin
            pend_q <= pend_q & wdata[PEND_BIT];
        end else if (hit && ie_q) begin
            pend_q <= 1'b1;
        end
    end

    assign mode_o   = mode_q;
    assign ie_o     = ie_q;
    assign pend_o   = pend_q;
    assign period_o = period_q;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PER_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv,
    input  logic              clr,
    input  logic [PER_W-1:0]  period,
    output logic [DATA_W-1:0] count_o,
    output logic              match_next
);
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] count_inc;

    assign count_inc = count_q + 1'b1;

    // Equality on the low field only: wrap is handled naturally
    assign match_next = (count_inc[PER_W-1:0] == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= wdata;
        end else if (clr) begin
            count_q <= '0;
        end else if (adv) begin
            count_q <= count_inc;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/tt_fsm.sv
module tt_fsm
    import tt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_en,
    input  logic    any_wr,
    input  logic    ctl_wr,
    input  tmode_e  new_mode,
    input  tmode_e  cur_mode,
    input  logic    match_next,
    output logic    adv,
    output logic    clr,
    output logic    hit,
    output tstate_e state_o
);
    tstate_e state_q;
    tstate_e state_d;
    logic    tick_ok;

    assign tick_ok = tick_en && !any_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = (new_mode == TM_OFF) ? ST_IDLE : ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (tick_ok && match_next && cur_mode == TM_ONESHOT) begin
                        state_d = ST_HALT;
                    end
                end
                ST_HALT: state_d = ST_HALT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        adv = 1'b0;
        clr = 1'b0;
        hit = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                if (tick_ok) begin
                    hit = match_next;
                    if (match_next && cur_mode == TM_RESTART) begin
                        clr = 1'b1;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            ST_HALT: ;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PER_W = DATA_W - HDR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic              ctl_wr;
    logic              cnt_wr;
    tmode_e            mode;
    logic              ie;
    logic              pend;
    logic [PER_W-1:0]  period;
    logic [DATA_W-1:0] count;
    logic              match_next;
    logic              adv;
    logic              clr;
    logic              hit;
    tstate_e           state;

    assign ctl_wr = reg_we && !reg_addr;
    assign cnt_wr = reg_we &&  reg_addr;

    tt_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .wdata    (reg_wdata),
        .hit      (hit),
        .mode_o   (mode),
        .ie_o     (ie),
        .pend_o   (pend),
        .period_o (period)
    );

    tt_counter #(.DATA_W(DATA_W), .PER_W(PER_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_wr     (cnt_wr),
        .wdata      (reg_wdata),
        .adv        (adv),
        .clr        (clr),
        .period     (period),
        .count_o    (count),
        .match_next (match_next)
    );

    tt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .any_wr     (reg_we),
        .ctl_wr     (ctl_wr),
        .new_mode   (tmode_e'(reg_wdata[DATA_W-1:DATA_W-2])),
        .cur_mode   (mode),
        .match_next (match_next),
        .adv        (adv),
        .clr        (clr),
        .hit        (hit),
        .state_o    (state)
    );

    assign reg_rdata = reg_addr ? count : {mode, ie, pend, period};
    assign irq       = pend & ie;
endmodule

// File: rtl/tt_checker.sv
module tt_checker
    import tt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic [DATA_W-1:0] count,
    input tmode_e            mode,
    input logic              ie,
    input logic              pend,
    input logic              hit,
    input tstate_e           state
);
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !reg_we) |=> $stable(count)); // R7
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_OFF && !reg_we) |=> $stable(count)); // R2
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(reg_we && !reg_addr)) |=> pend); // R5
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr) |=> (count == $past(reg_wdata))); // R9
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == TM_RESTART) |=> (count == '0)); // R6
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie && pend)); // R4
endmodule

bind tick_timer tt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .count     (count),
    .mode      (mode),
    .ie        (ie),
    .pend      (pend),
    .hit       (hit),
    .state     (state)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [1:0] M_OFF = 2'b00, M_RST = 2'b01, M_ONE = 2'b10, M_FREE = 2'b11;

    function automatic logic [31:0] ctl(logic [1:0] m, logic ie, logic pd, logic [27:0] per);
        return {m, ie, pd, per};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [31:0] d, logic with_tick = 1'b0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; tick_en = with_tick;
        @(negedge clk);
        reg_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic rd(logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 ctl reset", v, 32'h0);
        rd(1'b1, v); chk("R1 count reset", v, 32'h0);
        chk("R1 irq reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(1'b0, ctl(M_OFF, 1'b1, 1'b0, 28'd5));
        ticks(3);
        rd(1'b1, v); chk("R2 no count when off", v, 32'h0);
    endtask

    task automatic t_count_free();
        logic [31:0] v;
        wr(1'b0, ctl(M_FREE, 1'b0, 1'b0, 28'd100));
        wr(1'b1, 32'h0);
        ticks(4);
        rd(1'b1, v); chk("R2 count per tick", v, 32'd4);
        wr(1'b0, ctl(M_FREE, 1'b1, 1'b0, 28'd3));
        wr(1'b1, 32'h0);
        ticks(2);
        chk("R4 no irq before match", {31'h0, irq}, 32'h0);
        ticks(1);
        chk("R4 irq on match", {31'h0, irq}, 32'h1);
        rd(1'b0, v); chk("R4 pending bit", {31'h0, v[28]}, 32'h1);
        ticks(2);
        rd(1'b1, v); chk("R8 counts past match", v, 32'd5);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        wr(1'b0, ctl(M_FREE, 1'b1, 1'b1, 28'd3));
        rd(1'b0, v); chk("R5 write 1 keeps pending", {31'h0, v[28]}, 32'h1);
        chk("R5 irq kept", {31'h0, irq}, 32'h1);
        ticks(4);
        chk("R5 still pending", {31'h0, irq}, 32'h1);
        wr(1'b0, ctl(M_FREE, 1'b1, 1'b0, 28'd2));
        chk("R5 cleared by write 0", {31'h0, irq}, 32'h0);
        wr(1'b0, ctl(M_FREE, 1'b0, 1'b0, 28'd2));
        wr(1'b1, 32'h0);
        ticks(3);
        rd(1'b0, v); chk("R4 no pending with IE off", {31'h0, v[28]}, 32'h0);
        chk("R4 no irq with IE off", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(1'b0, ctl(M_RST, 1'b1, 1'b0, 28'd4));
        wr(1'b1, 32'h0);
        ticks(3);
        rd(1'b1, v); chk("R6 before match", v, 32'd3);
        chk("R6 irq low before match", {31'h0, irq}, 32'h0);
        ticks(1);
        rd(1'b1, v); chk("R6 cleared on match", v, 32'd0);
        chk("R4 irq in restart", {31'h0, irq}, 32'h1);
        ticks(2);
        rd(1'b1, v); chk("R6 counts again", v, 32'd2);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(1'b0, ctl(M_ONE, 1'b0, 1'b0, 28'd2));
        wr(1'b1, 32'h0);
        ticks(2);
        rd(1'b1, v); chk("R7 stops at match", v, 32'd2);
        ticks(3);
        rd(1'b1, v); chk("R7 frozen", v, 32'd2);
        wr(1'b0, ctl(M_ONE, 1'b0, 1'b0, 28'd10));
        ticks(1);
        rd(1'b1, v); chk("R7 resumes after mode write", v, 32'd3);
    endtask

    task automatic t_mask_wrap();
        logic [31:0] v;
        wr(1'b0, ctl(M_FREE, 1'b1, 1'b0, 28'd5));
        wr(1'b1, 32'hF000_0003);
        ticks(1);
        chk("R3 no early match", {31'h0, irq}, 32'h0);
        ticks(1);
        chk("R3 high bits ignored", {31'h0, irq}, 32'h1);
        wr(1'b0, ctl(M_FREE, 1'b1, 1'b0, 28'd1));
        wr(1'b1, 32'h0FFF_FFFE);
        ticks(2);
        chk("R3 no match before wrap", {31'h0, irq}, 32'h0);
        rd(1'b1, v); chk("R3 count at wrap", v, 32'h1000_0000);
        ticks(1);
        chk("R3 match after wrap", {31'h0, irq}, 32'h1);
        rd(1'b1, v); chk("R3 count after wrap", v, 32'h1000_0001);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(1'b0, ctl(M_FREE, 1'b0, 1'b0, 28'd1000));
        wr(1'b1, 32'h55, 1'b1);
        rd(1'b1, v); chk("R9 write beats tick", v, 32'h55);
        wr(1'b0, ctl(M_FREE, 1'b0, 1'b0, 28'd1000), 1'b1);
        rd(1'b1, v); chk("R2 tick dropped on ctl write", v, 32'h55);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        wr(1'b0, 32'hB000_0123);
        rd(1'b0, v); chk("R10 ctl readback layout", v, 32'hA000_0123);
        wr(1'b0, 32'h7ABC_DEF0);
        rd(1'b0, v); chk("R10 ctl readback restart", v, 32'h6ABC_DEF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_count_free();
        t_pending();
        t_restart();
        t_oneshot();
        t_mask_wrap();
        t_priority();
        t_layout();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule